// File: doc/BRIEF.md
# Ready-Qualified Word Capture Across Clock Domains

This block brings a slowly changing multi-bit word from a slower, unrelated source clock domain into a fast receiver clock domain. The source presents a data bus and a single ready strobe. While ready is high, the source keeps the bus unchanged. The receiver passes only the ready strobe through a chain of flip-flops clocked by the receiver clock. It never passes the data bits through their own synchronizers, because bits that each resolve metastability on their own could combine into a word that was never sent.

A rising edge on the synchronized ready marks a new word. On that cycle the receiver samples the held bus once into an output register and raises a valid flag for a single receiver cycle. The word stays on the output until the next capture. The source must hold each ready level, high or low, for at least two receiver clock periods, so that the synchronizer sees every pulse.

Top module: `ready_capture_sync`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, `cap_data` and `cap_valid` are 0 after that edge, and the synchronizer and edge history are cleared.
- R2: With the default two synchronizer stages, `cap_valid` is high after the third rising receiver edge that samples `src_ready` high following a low level. That is a latency of three receiver cycles from the input rise to the output.
- R3: `cap_valid` is high for exactly one receiver cycle for each low-to-high transition of `src_ready`, however long `src_ready` then stays high.
- R4: In the cycle that `cap_valid` is high, `cap_data` equals the value `src_data` held at the capture edge. `cap_data` keeps that value until the next capture.
- R5: Changes on `src_data` while `src_ready` is low, or while it stays high after a capture, never reach `cap_data`.
- R6: A ready pulse that is high for two receiver cycles and is followed by a low gap of two receiver cycles is captured. Back-to-back pulses of this minimum form each give their own capture.
- R7: If `src_ready` is already high when reset is released, the cleared synchronizer sees a rise. That word is captured once, three cycles after the first edge without reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst | input | 1 | Synchronous active-high reset |
| src_ready | input | 1 | Ready strobe from the source domain |
| src_data | input | DATA_W | Data bus from the source, held constant while ready is high |
| cap_data | output | DATA_W | Last captured word |
| cap_valid | output | 1 | One-cycle pulse marking a new word on cap_data |

## Verification
The bench holds ready high for a long stretch while changing the bus after the capture edge. A design that triggers on the ready level would pulse valid again or pick up the later value. Minimum-width pulses with minimum gaps catch a design that drops or merges close assertions. Bus changes while ready is low catch an output register that loads without a qualifying edge. Ready held high through reset release, and a reset in the middle of a pulse, catch a design whose edge history is not cleared or that captures twice across reset.

// File: rtl/cdc_capture_pkg.sv
package cdc_capture_pkg;
  localparam int DEFAULT_DATA_W = 8;
  localparam int MIN_SYNC_STAGES = 2;

  function automatic int capture_latency(input int stages);
    return stages + 1;
  endfunction
endpackage

// File: rtl/ready_sync_chain.sv
module ready_sync_chain #(
  parameter int STAGES = cdc_capture_pkg::MIN_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[LAST];

  // Requirement R2: the synchronized output follows the stage in front of it by one cycle.
  p_chain_shift_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sync_out == $past(chain[LAST-1]));

  // Requirement R1: the whole chain is clear after a reset edge.
  p_chain_reset_r1: assert property (@(posedge clk)
    rst |=> chain == '0);
endmodule

// File: rtl/ready_rise_detect.sv
module ready_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic rise
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (rst) level_d <= 1'b0;
    else     level_d <= level_in;
  end

  assign rise = level_in & ~level_d;

  // Requirement R3: a rise cannot repeat on the next cycle.
  p_no_double_rise_r3: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/word_capture_reg.sv
module word_capture_reg #(
  parameter int DATA_W = cdc_capture_pkg::DEFAULT_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dvalid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      dvalid <= 1'b0;
    end else begin
      dvalid <= load;
      if (load) dout <= din;
    end
  end

  // Requirement R4: the held word is unchanged while no load occurs.
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(dout));
endmodule

// File: rtl/ready_capture_sync.sv
module ready_capture_sync #(
  parameter int DATA_W      = cdc_capture_pkg::DEFAULT_DATA_W,
  parameter int SYNC_STAGES = cdc_capture_pkg::MIN_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] cap_data,
  output logic              cap_valid
);
  localparam int STAGES_USED =
    (SYNC_STAGES < cdc_capture_pkg::MIN_SYNC_STAGES) ? cdc_capture_pkg::MIN_SYNC_STAGES : SYNC_STAGES;

  logic ready_sync;
  logic ready_rise;

  ready_sync_chain #(.STAGES(STAGES_USED)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (src_ready),
    .sync_out (ready_sync)
  );

  ready_rise_detect u_rise (
    .clk      (clk),
    .rst      (rst),
    .level_in (ready_sync),
    .rise     (ready_rise)
  );

  word_capture_reg #(.DATA_W(DATA_W)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .load   (ready_rise),
    .din    (src_data),
    .dout   (cap_data),
    .dvalid (cap_valid)
  );

  // Requirement R1: outputs are cleared after a reset edge.
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!cap_valid && cap_data == '0));

  // Requirement R3: valid never lasts two cycles.
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cap_valid |=> !cap_valid);

  // Requirement R4: a valid word is the bus value from the capture edge.
  p_capture_value_r4: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> cap_data == $past(src_data));

  // Requirement R2: valid only follows a synchronized ready that was high.
  p_valid_after_sync_r2: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> $past(ready_sync));
endmodule

// File: tb/tb_ready_capture_sync.sv
module tb_ready_capture_sync;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         src_ready;
  logic [W-1:0] src_data;
  logic [W-1:0] cap_data;
  logic         cap_valid;

  int checks = 0;
  int errors = 0;
  int captures_seen = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Reference state: ready history and expected outputs.
  int hist[$] = '{0, 0, 0};
  logic         exp_valid = 1'b0;
  logic [W-1:0] exp_data = '0;

  always #2 clk = ~clk;

  ready_capture_sync #(.DATA_W(W)) dut (
    .clk       (clk),
    .rst       (rst),
    .src_ready (src_ready),
    .src_data  (src_data),
    .cap_data  (cap_data),
    .cap_valid (cap_valid)
  );

  always @(posedge clk) begin
    if (rst) begin
      hist = '{0, 0, 0};
      exp_valid = 1'b0;
      exp_data = '0;
    end else begin
      // hist[0]: ready one edge back, hist[1]: two back, hist[2]: three back.
      exp_valid = (hist[1] == 1) && (hist[2] == 0);
      if (exp_valid) exp_data = src_data;
      hist.push_front(int'(src_ready));
      void'(hist.pop_back());
    end
    #1;
    checks++;
    if (cap_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s valid: actual %b expected %b at %0t", cur_req, cap_valid, exp_valid, $time);
    end
    checks++;
    if (cap_data !== exp_data) begin
      errors++;
      $display("FAIL %s data: actual %h expected %h at %0t", cur_req, cap_data, exp_data, $time);
    end
    if (cap_valid === 1'b1) captures_seen++;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic [W-1:0] d, input int hi, input int lo);
    @(negedge clk);
    src_data = d;
    src_ready = 1'b1;
    idle(hi);
    src_ready = 1'b0;
    idle(lo);
  endtask

  task automatic count_check(input string req, input int expected);
    checks++;
    if (captures_seen != expected) begin
      errors++;
      $display("FAIL %s capture count: actual %0d expected %0d", req, captures_seen, expected);
    end
  endtask

  initial begin
    rst = 1'b1;
    src_ready = 1'b0;
    src_data = '0;
    idle(4);
    // R1: reset state
    @(negedge clk);
    checks++;
    if (cap_valid !== 1'b0 || cap_data !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %b/%h expected 0/00", cap_valid, cap_data);
    end
    rst = 1'b0;

    // R2 latency, single capture
    cur_req = "R2";
    pulse(8'hA5, 3, 6);
    count_check("R2", 1);

    // R5: bus toggles with ready low
    cur_req = "R5";
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      src_data = 8'(i * 37 + 1);
    end
    idle(4);
    checks++;
    if (cap_data !== 8'hA5) begin
      errors++;
      $display("FAIL R5 held word: actual %h expected a5", cap_data);
    end

    // R3: long hold, bus changes after capture must be ignored
    cur_req = "R3";
    @(negedge clk);
    src_data = 8'h3C;
    src_ready = 1'b1;
    idle(5);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      src_data = 8'(8'hC0 + i);
    end
    checks++;
    if (cap_data !== 8'h3C) begin
      errors++;
      $display("FAIL R5 word during long ready: actual %h expected 3c", cap_data);
    end
    src_ready = 1'b0;
    idle(6);
    count_check("R3", 2);

    // R6: minimum pulses back to back
    cur_req = "R6";
    pulse(8'h11, 2, 2);
    pulse(8'h22, 2, 2);
    pulse(8'h33, 2, 2);
    pulse(8'hFF, 2, 6);
    count_check("R6", 6);

    // R4: varied words
    cur_req = "R4";
    pulse(8'h00, 4, 4);
    pulse(8'h80, 3, 3);
    pulse(8'h7E, 5, 5);
    count_check("R4", 9);

    // R7: ready high across reset release
    cur_req = "R7";
    @(negedge clk);
    rst = 1'b1;
    src_data = 8'h5A;
    src_ready = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(8);
    src_ready = 1'b0;
    idle(5);
    count_check("R7", 10);

    // R1: reset in the middle of a pulse, then normal operation
    cur_req = "R1";
    @(negedge clk);
    src_data = 8'h99;
    src_ready = 1'b1;
    idle(1);
    rst = 1'b1;
    src_ready = 1'b0;
    idle(3);
    rst = 1'b0;
    idle(5);
    count_check("R1", 10);
    pulse(8'h42, 2, 6);
    count_check("R1", 11);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule